// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address using a flat, one-level page table kept in memory. A requester hands it a virtual address and an access kind (read, write or execute). The walker takes the page number from the upper address bits and adds the scaled page number to a table base address to find the entry. It then reads that entry over a single-beat memory port and checks it for validity, residency and permission. It answers with either a physical address, formed from the entry's frame number and the untouched page offset, or a fault code.

On a successful access the walker keeps the entry's usage bits current. It marks the entry as referenced and, for writes, as modified. It writes the entry back only when one of those bits actually changes, and it holds the answer until that write has been accepted. Only one translation is in flight at a time. With the default parameters, pages are 16 bytes, virtual addresses are 6 bits wide (4 pages), physical addresses are 7 bits wide (8 frames), and entries are 2 bytes.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_valid_o` are 0.
- R2: A request is taken on a clock where `req_valid_i` and `req_ready_o` are both 1. From the next cycle, `req_ready_o` stays 0 until the clock on which `rsp_valid_o` and `rsp_ready_i` are both 1. On the cycle after acceptance, a memory read is presented.
- R3: The entry is read exactly once, at byte address `tbl_base_i + vpn * PTE_BYTES`, where vpn is the virtual address above the offset (bits [5:4] by default). Each memory word is one whole entry.
- R4: On success, `rsp_paddr_o` equals the entry's frame number concatenated with the request's offset bits. The offset is bits [3:0] by default and is passed through unchanged.
- R5: Entry layout: the frame number sits in bits [PFN_W-1:0], with PFN_W = 3 by default. The flags are bit 8 valid, bit 9 present, bit 10 read allowed, bit 11 write allowed, bit 12 execute allowed, bit 13 referenced and bit 14 modified.
- R6: `rsp_fault_o` codes, checked in this priority: valid clear gives 1; otherwise present clear gives 2; otherwise an access not allowed by the permission bits gives 3; otherwise 0. Access codes are 0 read, 1 write, 2 execute; code 3 always gives fault 3. A faulting response carries physical address 0.
- R7: A successful access sets the referenced bit, and a successful write also sets the modified bit. The entry is written back to its own address only if this changes it. A faulting access never writes.
- R8: The response appears only after any write-back has been accepted (`mem_ready_i`). While `mem_ready_i` is 0, a memory request keeps its valid, address, write flag and data unchanged.
- R9: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response stays valid and its address and fault code stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base_i | input | MAW | Page table base byte address, sampled on acceptance |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid_o | output | 1 | Result present |
| rsp_ready_i | input | 1 | Requester takes the result |
| rsp_paddr_o | output | PA_W | Physical address (0 on fault) |
| rsp_fault_o | output | 2 | Fault code |
| mem_valid_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for entry write-back, 0 for entry read |
| mem_addr_o | output | MAW | Entry byte address |
| mem_wdata_o | output | 8*PTE_BYTES | Updated entry for write-back |
| mem_ready_i | input | 1 | Memory completes the access this cycle |
| mem_rdata_i | input | 8*PTE_BYTES | Entry read data, valid with `mem_ready_i` on a read |

## Verification
The bench aims at the fault priority with entries that break several checks at once. One entry is both invalid and not present, and one is invalid but present. A design that ordered the checks wrongly would report "not present" or "protection" for them. It repeats accesses to the same entry so that the second access finds the usage bits already set. A design that always wrote back would issue a spurious memory write, and one that never did would leave the referenced or modified bit clear in the table. It stalls the read, the write-back and the response handshake by several cycles to catch a response issued before the write-back finished, and a response that changes or drops while the requester stalls. It also compares the ready signal on every clock to catch a walker that accepts a second request mid-walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_ABSENT  = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WBACK,
    ST_RESP
  } walk_st_e;

  // Flag positions inside a table entry (frame number occupies the low bits)
  localparam int BIT_VALID = 8;
  localparam int BIT_PRES  = 9;
  localparam int BIT_RPERM = 10;
  localparam int BIT_WPERM = 11;
  localparam int BIT_XPERM = 12;
  localparam int BIT_REF   = 13;
  localparam int BIT_DIRTY = 14;
  localparam int FLAG_TOP  = 14;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VA_W      = 6,
  parameter int OFF_W     = 4,
  parameter int MAW       = 8,
  parameter int PTE_BYTES = 2
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [MAW-1:0]   base_i,
  output logic [OFF_W-1:0] off_o,
  output logic [MAW-1:0]   ent_addr_o
);
  localparam int  VPN_W = VA_W - OFF_W;
  localparam int  SH    = $clog2(PTE_BYTES);
  localparam bit  POW2  = ((1 << SH) == PTE_BYTES);

  logic [VPN_W-1:0] vpn;
  logic [MAW-1:0]   scaled;

  assign vpn   = vaddr_i[VA_W-1:OFF_W];
  assign off_o = vaddr_i[OFF_W-1:0];

  // Entry size picks a shifter or a constant multiplier
  generate
    if (POW2) begin : g_shift
      assign scaled = MAW'(vpn) << SH;
    end else begin : g_mul
      assign scaled = MAW'(vpn) * MAW'(PTE_BYTES);
    end
  endgenerate

  assign ent_addr_o = base_i + scaled;

endmodule

// File: rtl/pt_pte_eval.sv
module pt_pte_eval
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 16,
  parameter int PFN_W = 3
) (
  input  logic [PTE_W-1:0] pte_i,
  input  acc_e             acc_i,
  output fault_e           fault_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic [PTE_W-1:0] pte_upd_o,
  output logic             wback_o
);
  logic allow;

  always_comb begin
    case (acc_i)
      ACC_RD:  allow = pte_i[BIT_RPERM];
      ACC_WR:  allow = pte_i[BIT_WPERM];
      ACC_EX:  allow = pte_i[BIT_XPERM];
      default: allow = 1'b0;
    endcase

    if (!pte_i[BIT_VALID])      fault_o = FLT_INVALID;
    else if (!pte_i[BIT_PRES])  fault_o = FLT_ABSENT;
    else if (!allow)            fault_o = FLT_PROT;
    else                        fault_o = FLT_NONE;

    pte_upd_o = pte_i;
    if (fault_o == FLT_NONE) begin
      pte_upd_o[BIT_REF] = 1'b1;
      if (acc_i == ACC_WR) pte_upd_o[BIT_DIRTY] = 1'b1;
    end
    wback_o = (pte_upd_o != pte_i);
  end

  assign pfn_o = pte_i[PFN_W-1:0];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 6,
  parameter int PA_W       = 7,
  parameter int PAGE_BYTES = 16,
  parameter int MAW        = 8,
  parameter int PTE_BYTES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MAW-1:0]           tbl_base_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [VA_W-1:0]          req_vaddr_i,
  input  logic [1:0]               req_acc_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [PA_W-1:0]          rsp_paddr_o,
  output logic [1:0]               rsp_fault_o,
  output logic                     mem_valid_o,
  output logic                     mem_we_o,
  output logic [MAW-1:0]           mem_addr_o,
  output logic [8*PTE_BYTES-1:0]   mem_wdata_o,
  input  logic                     mem_ready_i,
  input  logic [8*PTE_BYTES-1:0]   mem_rdata_i
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PFN_W = PA_W - OFF_W;
  localparam int PTE_W = 8 * PTE_BYTES;

  walk_st_e          st_q;
  logic [OFF_W-1:0]  off_q;
  acc_e              acc_q;
  logic [MAW-1:0]    addr_q;
  logic [PTE_W-1:0]  pte_q;
  logic [PTE_W-1:0]  wdata_q;
  logic [PA_W-1:0]   paddr_q;
  fault_e            fault_q;

  logic [OFF_W-1:0]  off_n;
  logic [MAW-1:0]    ent_n;
  fault_e            flt;
  logic [PFN_W-1:0]  pfn;
  logic [PTE_W-1:0]  upd;
  logic              need_wb;

  pt_addr_gen #(
    .VA_W(VA_W), .OFF_W(OFF_W), .MAW(MAW), .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .vaddr_i    (req_vaddr_i),
    .base_i     (tbl_base_i),
    .off_o      (off_n),
    .ent_addr_o (ent_n)
  );

  pt_pte_eval #(
    .PTE_W(PTE_W), .PFN_W(PFN_W)
  ) u_eval (
    .pte_i     (pte_q),
    .acc_i     (acc_q),
    .fault_o   (flt),
    .pfn_o     (pfn),
    .pte_upd_o (upd),
    .wback_o   (need_wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      off_q   <= '0;
      acc_q   <= ACC_RD;
      addr_q  <= '0;
      pte_q   <= '0;
      wdata_q <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          off_q  <= off_n;
          acc_q  <= acc_e'(req_acc_i);
          addr_q <= ent_n;
          st_q   <= ST_READ;
        end
        ST_READ: if (mem_ready_i) begin
          pte_q <= mem_rdata_i;
          st_q  <= ST_EVAL;
        end
        ST_EVAL: begin
          fault_q <= flt;
          wdata_q <= upd;
          paddr_q <= (flt == FLT_NONE) ? {pfn, off_q} : '0;
          st_q    <= need_wb ? ST_WBACK : ST_RESP;
        end
        ST_WBACK: if (mem_ready_i) st_q <= ST_RESP;
        ST_RESP:  if (rsp_ready_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_valid_o = (st_q == ST_READ) || (st_q == ST_WBACK);
  assign mem_we_o    = (st_q == ST_WBACK);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;

  // R2: idle excludes any memory or response activity
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> (!mem_valid_o && !rsp_valid_o));

  // R2: acceptance leads straight to a table read and drops ready
  assert_read_follows_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o) |=> (mem_valid_o && !mem_we_o && !req_ready_o));

  // R8: a stalled memory request is held unchanged
  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R9: a stalled response is held unchanged
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

  // R4: the offset bits reach the physical address unchanged
  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_fault_o == 2'd0) |-> (rsp_paddr_o[OFF_W-1:0] == off_q));

  // R6: faulting responses carry a zero address
  assert_fault_zero_pa_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_fault_o != 2'd0) |-> (rsp_paddr_o == '0));

  // R7: a write-back always changes the entry and only follows a success
  assert_wb_changes_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && mem_we_o) |-> (mem_wdata_o != pte_q && fault_q == FLT_NONE));

endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tbl_base_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [5:0]  req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [6:0]  rsp_paddr_o;
  logic [1:0]  rsp_fault_o;
  logic        mem_valid_o;
  logic        mem_we_o;
  logic [7:0]  mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;

  always #2.5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst), .tbl_base_i(tbl_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .req_acc_i(req_acc_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_paddr_o(rsp_paddr_o), .rsp_fault_o(rsp_fault_o),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  logic [15:0] tmem [0:127];
  int rd_lat = 0, wr_lat = 0, wait_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0]  last_rd_addr = '0, last_wr_addr = '0;
  logic [15:0] last_wr_data = '0;
  logic busy_m = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Behavioural table memory with programmable wait states
  always @(negedge clk) begin
    mem_ready_i = 1'b0;
    if (!rst && mem_valid_o) begin
      if (wait_cnt >= (mem_we_o ? wr_lat : rd_lat)) begin
        mem_ready_i = 1'b1;
        wait_cnt = 0;
        if (mem_we_o) begin
          wr_cnt++;
          last_wr_addr = mem_addr_o;
          last_wr_data = mem_wdata_o;
          tmem[mem_addr_o[7:1]] = mem_wdata_o;
        end else begin
          rd_cnt++;
          last_rd_addr = mem_addr_o;
          mem_rdata_i = tmem[mem_addr_o[7:1]];
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  // Reference occupancy: busy from acceptance to response handshake
  always @(posedge clk) begin
    if (rst) busy_m <= 1'b0;
    else if (!busy_m && req_valid_i && req_ready_o) busy_m <= 1'b1;
    else if (busy_m && rsp_valid_o && rsp_ready_i) busy_m <= 1'b0;
  end

  always @(negedge clk) begin
    if (!rst) chk("R2 ready vs occupancy", req_ready_o, !busy_m);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      compared++;
      mismatched++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input bit v, p, r, w, x, rf, d, input logic [2:0] pfn);
    logic [15:0] e;
    e = '0;
    e[2:0] = pfn;
    e[8] = v; e[9] = p; e[10] = r; e[11] = w; e[12] = x; e[13] = rf; e[14] = d;
    return e;
  endfunction

  task automatic xlate(input logic [7:0] base, input logic [5:0] va, input logic [1:0] acc,
                       input int rdl, input int wrl, input int rspd);
    logic [7:0]  ent;
    logic [15:0] pte, npte;
    logic [1:0]  ef;
    logic [6:0]  epa;
    bit ok;
    int r0, w0;
    ent = base + 8'(int'(va[5:4]) * 2);
    pte = tmem[ent[7:1]];
    ok  = (acc == 2'd0) ? pte[10] : (acc == 2'd1) ? pte[11] : (acc == 2'd2) ? pte[12] : 1'b0;
    if (!pte[8])      ef = 2'd1;
    else if (!pte[9]) ef = 2'd2;
    else if (!ok)     ef = 2'd3;
    else              ef = 2'd0;
    npte = pte;
    if (ef == 2'd0) begin
      npte[13] = 1'b1;
      if (acc == 2'd1) npte[14] = 1'b1;
    end
    epa = (ef == 2'd0) ? {pte[2:0], va[3:0]} : 7'd0;
    rd_lat = rdl; wr_lat = wrl;
    r0 = rd_cnt; w0 = wr_cnt;

    @(negedge clk);
    tbl_base_i = base; req_vaddr_i = va; req_acc_i = acc; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk);

    chk("R6 fault code", rsp_fault_o, ef);
    chk("R4 physical address", rsp_paddr_o, epa);
    chk("R3 one entry read", rd_cnt - r0, 1);
    chk("R3 entry address", last_rd_addr, ent);
    chk("R7 write-back count", wr_cnt - w0, (npte != pte) ? 1 : 0);
    if (npte != pte) begin
      chk("R7 written entry", last_wr_data, npte);
      chk("R8 written address", last_wr_addr, ent);
    end
    chk("R7 table entry after walk", tmem[ent[7:1]], npte);

    repeat (rspd) @(negedge clk);
    chk("R9 response still valid", rsp_valid_o, 1);
    chk("R9 fault unchanged", rsp_fault_o, ef);
    chk("R9 address unchanged", rsp_paddr_o, epa);
    rsp_ready_i = 1'b1;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    chk("R2 response dropped after handshake", rsp_valid_o, 0);
    chk("R2 ready after handshake", req_ready_o, 1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) tmem[i] = '0;
    // base 0x20
    tmem[8'h10] = mk(1,1,1,0,0,0,0,3'd5);
    tmem[8'h11] = mk(1,1,1,1,0,1,0,3'd2);
    tmem[8'h12] = mk(1,1,0,0,1,0,0,3'd7);
    tmem[8'h13] = mk(0,0,1,1,1,0,0,3'd1);
    // base 0x60
    tmem[8'h30] = mk(1,0,1,1,1,0,0,3'd3);
    tmem[8'h31] = mk(1,1,1,1,1,1,1,3'd4);
    tmem[8'h32] = mk(1,1,1,1,0,0,0,3'd0);
    tmem[8'h33] = mk(0,1,1,1,1,0,0,3'd6);

    repeat (3) @(negedge clk);
    chk("R1 reset ready", req_ready_o, 1);
    chk("R1 reset rsp_valid", rsp_valid_o, 0);
    chk("R1 reset mem_valid", mem_valid_o, 0);
    rst = 1'b0;
    @(negedge clk);

    xlate(8'h20, 6'h0A, 2'd0, 0, 0, 0); // R7 read sets referenced
    xlate(8'h20, 6'h0A, 2'd0, 1, 0, 1); // R7 no change, no write
    xlate(8'h20, 6'h13, 2'd1, 0, 0, 0); // R7 write sets modified
    xlate(8'h20, 6'h13, 2'd1, 0, 0, 0); // R7 no change
    xlate(8'h20, 6'h15, 2'd0, 0, 0, 0); // R4 read on rw page
    xlate(8'h20, 6'h2F, 2'd2, 0, 1, 0); // R4 execute
    xlate(8'h20, 6'h20, 2'd0, 0, 0, 0); // R6 read on exec-only
    xlate(8'h20, 6'h01, 2'd1, 0, 0, 0); // R6 write on read-only
    xlate(8'h20, 6'h01, 2'd3, 0, 0, 0); // R6 reserved access code
    xlate(8'h20, 6'h33, 2'd0, 0, 0, 0); // R6 invalid beats not present
    xlate(8'h60, 6'h07, 2'd0, 2, 0, 0); // R6 not present
    xlate(8'h60, 6'h3C, 2'd2, 0, 0, 2); // R6 invalid though present
    xlate(8'h60, 6'h1F, 2'd1, 3, 0, 4); // R5 all flags already set
    xlate(8'h60, 6'h29, 2'd1, 2, 3, 2); // R8 slow write-back
    xlate(8'h60, 6'h29, 2'd1, 0, 0, 0); // R7 repeat after write-back

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule